// File: doc/BRIEF.md
# Two-Channel Output Compare Timer

This block pairs a 16-bit free-running counter with two output compare channels. The counter's clock comes from a prescaler. It can run at the system clock divided by 2, 4 or 8, or it can follow rising edges of an external clock pin. Each channel holds a 16-bit compare value, which software writes as two bytes over a byte-wide register bus.

When the counter reaches a channel's compare value, the channel sets its status flag. If the channel's output is enabled, it also loads a programmed level into its pin latch. One shared interrupt enable turns any set flag into an interrupt request.

Software can force a channel's pin latch to its programmed level without a compare event. A mode input blocks forcing while a pulse-generating mode owns the pins. A write to the upper byte of a compare value suspends that channel's matching until the lower byte follows. This stops a half-updated value from producing a spurious event.

Top module: `ocu_dual`

## Requirements
- R1: After reset, both pin latches are 0, both pin drive enables are 0, irq is 0, all status flags are 0, the counter is 0 and the prescale select is divide-by-2.
- R2: The counter advances by one per timer tick. The prescale select is bits [1:0] of register 0: 00 gives divide-by-2, 01 gives divide-by-4, 10 gives divide-by-8, and 11 gives external clock. The external pin passes through two synchronizing flops, and each rising edge of the synchronized signal produces one tick. The counter reads back at address 14 (upper byte) and address 15 (lower byte).
- R3: In divide-by-2 mode, a channel's flag sets on the tick that moves the counter onto the compare value.
- R4: In divide-by-4, divide-by-8 and external modes, a channel's flag sets on the tick that moves the counter from the compare value to the compare value plus one.
- R5: Channel i's compare value sits at address 3+2i (upper byte) and 4+2i (lower byte). A write to the upper byte blocks matches on that channel until the lower byte is written.
- R6: On a match with the channel enabled, the channel's level bit (register 1, bit i) is copied into its pin latch. With the channel disabled, the latch keeps its value but the flag still sets.
- R7: pin_oe[i] equals the channel enable bit (register 0, bit 3+i).
- R8: A register 1 write with force bit 2+i set loads the written level bit i into pin latch i and sets no flag. While hold_force is 1, force bits do nothing.
- R9: irq is 1 exactly when the interrupt enable (register 0, bit 2) is 1 and at least one flag is set.
- R10: A flag clears when software reads the status register (address 2; flag i is bit i) while the flag is set, and then reads or writes that channel's lower compare byte. A match in the same cycle keeps the flag set.
- R11: Force bits read back as 0, and unused bits of registers 0, 1 and 2 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (reads have side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| ext_clk | input | 1 | External timer clock, asynchronous |
| hold_force | input | 1 | High while a pulse mode owns the pins; blocks forcing |
| pin_q | output | NCH (2) | Output compare pin latches |
| pin_oe | output | NCH (2) | Pin drive enables; low leaves the pin as general I/O |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that no register is accessed while reset is held. They also assume a read and a write never hit the same address in one cycle, and that the prescale select stays at divide-by-2 for the whole cycle after a divide-by-2 tick unless software switches it to external mode. The stimulus drives every register access as a one-cycle strobe after reset has fully released. It issues reads and writes one at a time. It toggles ext_clk no faster than every three system clocks, so each external edge survives the synchronizer as a separate tick.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  localparam int BW = 8;
  localparam int AW = 4;
  localparam int A_CTRL     = 0;
  localparam int A_LEVEL    = 1;
  localparam int A_STAT     = 2;
  localparam int A_CMP_BASE = 3;
  localparam int A_CNTH     = 14;
  localparam int A_CNTL     = 15;

  typedef enum logic [1:0] {
    PS_DIV2 = 2'b00,
    PS_DIV4 = 2'b01,
    PS_DIV8 = 2'b10,
    PS_EXT  = 2'b11
  } ps_e;
endpackage

// File: rtl/ocu_timebase.sv
module ocu_timebase
  import ocu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ps_e              ps,
  input  logic             ext_clk,
  output logic             tick,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [2:0]       div_q, div_d;
  logic [2:0]       sync_q, sync_d;   // [0],[1] synchronizer, [2] previous
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    div_d  = div_q + 3'd1;
    sync_d = {sync_q[1], sync_q[0], ext_clk};
    case (ps)
      PS_DIV2: tick = div_q[0];
      PS_DIV4: tick = &div_q[1:0];
      PS_DIV8: tick = &div_q;
      default: tick = sync_q[1] & ~sync_q[2];
    endcase
    cnt_d = tick ? cnt + ONE : cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sync_q <= '0;
      cnt    <= '0;
    end else begin
      div_q  <= div_d;
      sync_q <= sync_d;
      cnt    <= cnt_d;
    end
  end

  // R2: divide-by-2 never ticks on two cycles in a row
  p_div2_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ps == PS_DIV2) |=> (!tick || ps == PS_EXT));

  // R2: each tick advances the counter by exactly one
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + ONE);
endmodule

// File: rtl/ocu_channel.sv
module ocu_channel
  import ocu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             fast,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic             acc_lo,
  input  logic [BW-1:0]    wdata,
  input  logic             stat_rd,
  input  logic             en,
  input  logic             lvl,
  input  logic             frc,
  input  logic             frc_lvl,
  output logic [CNT_W-1:0] cmp,
  output logic             flag,
  output logic             pin
);
  localparam int HALF = CNT_W / 2;
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [CNT_W-1:0] cmp_d;
  logic             armed_q, armed_d;
  logic             clr_q, clr_d;
  logic             flag_d, pin_d;
  logic             hit, match;

  always_comb begin
    cmp_d = cmp;
    if (wr_hi) cmp_d = {wdata, cmp[HALF-1:0]};
    else if (wr_lo) cmp_d = {cmp[CNT_W-1:HALF], wdata};

    armed_d = wr_hi ? 1'b1 : (wr_lo ? 1'b0 : armed_q);

    // fast prescale compares the value being entered, slow ones the value being left
    hit   = fast ? ((cnt + ONE) == cmp) : (cnt == cmp);
    match = tick & ~armed_q & hit;

    clr_d = stat_rd ? flag : (acc_lo ? 1'b0 : clr_q);

    if (match) flag_d = 1'b1;
    else if (acc_lo && clr_q) flag_d = 1'b0;
    else flag_d = flag;

    if (frc) pin_d = frc_lvl;
    else if (match && en) pin_d = lvl;
    else pin_d = pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp     <= '0;
      armed_q <= 1'b0;
      clr_q   <= 1'b0;
      flag    <= 1'b0;
      pin     <= 1'b0;
    end else begin
      cmp     <= cmp_d;
      armed_q <= armed_d;
      clr_q   <= clr_d;
      flag    <= flag_d;
      pin     <= pin_d;
    end
  end

  // R3/R4: a flag only rises on a timer tick
  p_flag_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick));

  // R5: no new flag while the upper byte waits for its lower half
  p_lockout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(armed_q) |-> !$rose(flag));

  // R8: a force loads the written level
  p_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frc |=> pin == $past(frc_lvl));
endmodule

// File: rtl/ocu_regs.sv
module ocu_regs
  import ocu_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [AW-1:0]             addr,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [BW-1:0]             wdata,
  input  logic                      hold_force,
  input  logic [CNT_W-1:0]          cnt,
  input  logic [NCH-1:0][CNT_W-1:0] cmp,
  input  logic [NCH-1:0]            flags,
  output ps_e                       ps,
  output logic                      irq_en,
  output logic [NCH-1:0]            en,
  output logic [NCH-1:0]            lvl,
  output logic [NCH-1:0]            frc,
  output logic [NCH-1:0]            frc_lvl,
  output logic [NCH-1:0]            wr_hi,
  output logic [NCH-1:0]            wr_lo,
  output logic [NCH-1:0]            acc_lo,
  output logic                      stat_rd,
  output logic [BW-1:0]             rdata
);
  logic [1:0]     ps_q, ps_d;
  logic           ie_d;
  logic [NCH-1:0] en_d, lvl_d;
  logic           wr_ctrl, wr_level;

  assign wr_ctrl  = wr_en && (addr == AW'(A_CTRL));
  assign wr_level = wr_en && (addr == AW'(A_LEVEL));
  assign stat_rd  = rd_en && (addr == AW'(A_STAT));
  assign ps       = ps_e'(ps_q);
  assign frc      = (wr_level && !hold_force) ? wdata[NCH +: NCH] : '0;
  assign frc_lvl  = wdata[NCH-1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    localparam int HI_A = A_CMP_BASE + 2 * i;
    localparam int LO_A = HI_A + 1;
    assign wr_hi[i]  = wr_en && (addr == AW'(HI_A));
    assign wr_lo[i]  = wr_en && (addr == AW'(LO_A));
    assign acc_lo[i] = (wr_en || rd_en) && (addr == AW'(LO_A));
  end

  always_comb begin
    ps_d  = ps_q;
    ie_d  = irq_en;
    en_d  = en;
    lvl_d = lvl;
    if (wr_ctrl) begin
      ps_d = wdata[1:0];
      ie_d = wdata[2];
      en_d = wdata[3 +: NCH];
    end
    if (wr_level) lvl_d = wdata[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q   <= '0;
      irq_en <= 1'b0;
      en     <= '0;
      lvl    <= '0;
    end else begin
      ps_q   <= ps_d;
      irq_en <= ie_d;
      en     <= en_d;
      lvl    <= lvl_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(A_CTRL)) begin
      rdata[1:0]       = ps_q;
      rdata[2]         = irq_en;
      rdata[3 +: NCH]  = en;
    end else if (addr == AW'(A_LEVEL)) begin
      rdata[NCH-1:0] = lvl;
    end else if (addr == AW'(A_STAT)) begin
      rdata[NCH-1:0] = flags;
    end else if (addr == AW'(A_CNTH)) begin
      rdata = cnt[CNT_W-1 -: BW];
    end else if (addr == AW'(A_CNTL)) begin
      rdata = cnt[BW-1:0];
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (addr == AW'(A_CMP_BASE + 2 * i)) rdata = cmp[i][CNT_W-1 -: BW];
        if (addr == AW'(A_CMP_BASE + 2 * i + 1)) rdata = cmp[i][BW-1:0];
      end
    end
  end
endmodule

// File: rtl/ocu_dual.sv
module ocu_dual
  import ocu_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int CNT_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     addr,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata,
  input  logic           ext_clk,
  input  logic           hold_force,
  output logic [NCH-1:0] pin_q,
  output logic [NCH-1:0] pin_oe,
  output logic           irq
);
  logic [1:0]                rs_q;
  logic                      rst_i;
  ps_e                       ps;
  logic                      tick, irq_en;
  logic [CNT_W-1:0]          cnt;
  logic [NCH-1:0][CNT_W-1:0] cmp;
  logic [NCH-1:0]            flags, en, lvl, frc, frc_lvl, wr_hi, wr_lo, acc_lo;
  logic                      stat_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  ocu_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_i), .ps(ps), .ext_clk(ext_clk), .tick(tick), .cnt(cnt)
  );

  ocu_regs #(.NCH(NCH), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_i), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .hold_force(hold_force), .cnt(cnt), .cmp(cmp), .flags(flags),
    .ps(ps), .irq_en(irq_en), .en(en), .lvl(lvl), .frc(frc), .frc_lvl(frc_lvl),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .acc_lo(acc_lo), .stat_rd(stat_rd), .rdata(rdata)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ocu_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_i), .tick(tick), .fast(ps == PS_DIV2), .cnt(cnt),
      .wr_hi(wr_hi[i]), .wr_lo(wr_lo[i]), .acc_lo(acc_lo[i]), .wdata(wdata),
      .stat_rd(stat_rd), .en(en[i]), .lvl(lvl[i]), .frc(frc[i]),
      .frc_lvl(frc_lvl[i]), .cmp(cmp[i]), .flag(flags[i]), .pin(pin_q[i])
    );
  end

  assign pin_oe = en;
  assign irq    = irq_en & (|flags);

  // R7: a control write sets the pin drive enables one cycle later
  p_oe_follows_r7: assert property (@(posedge clk) disable iff (!rst_i)
    ($past(rst_i) && $past(wr_en) && $past(addr) == 4'(A_CTRL))
      |-> pin_oe == $past(wdata[3 +: NCH]));

  // R9: a rising interrupt needs a new flag or a new enable
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(irq) |-> ($past(flags) != flags || $rose(irq_en)));
endmodule

// File: tb/sim_ocu_dual.sv
module sim_ocu_dual;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] addr;
  logic       wr_en, rd_en, ext_clk, hold_force;
  logic [7:0] wdata, rdata;
  logic [1:0] pin_q, pin_oe;
  logic       irq;

  always #10 clk = ~clk;

  ocu_dual u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .ext_clk(ext_clk), .hold_force(hold_force),
    .pin_q(pin_q), .pin_oe(pin_oe), .irq(irq)
  );

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string cur_tag = "";

  // behavioural reference state
  logic [1:0]  m_rs;
  logic [2:0]  m_div;
  logic        m_s0, m_s1, m_pv;
  logic [15:0] m_cnt;
  logic [15:0] m_cmp [2];
  logic [1:0]  m_arm, m_clr, m_flag, m_pin, m_en, m_lvl, m_ps;
  logic        m_ie;

  task automatic mreset();
    m_div = 0; m_s0 = 0; m_s1 = 0; m_pv = 0; m_cnt = 0;
    m_cmp[0] = 0; m_cmp[1] = 0;
    m_arm = 0; m_clr = 0; m_flag = 0; m_pin = 0; m_en = 0; m_lvl = 0;
    m_ps = 0; m_ie = 0;
  endtask

  task automatic mstep();
    bit tk;
    bit [1:0] mt, frc, lo_acc, lo_wr, hi_wr;
    logic [1:0] old_flag;
    case (m_ps)
      2'd0: tk = m_div[0];
      2'd1: tk = (m_div[1:0] == 2'b11);
      2'd2: tk = (m_div == 3'b111);
      default: tk = m_s1 && !m_pv;
    endcase
    for (int i = 0; i < 2; i++) begin
      hi_wr[i]  = wr_en && addr == 4'(3 + 2 * i);
      lo_wr[i]  = wr_en && addr == 4'(4 + 2 * i);
      lo_acc[i] = (wr_en || rd_en) && addr == 4'(4 + 2 * i);
      if (m_ps == 0) mt[i] = tk && !m_arm[i] && (16'(m_cnt + 1) == m_cmp[i]);
      else           mt[i] = tk && !m_arm[i] && (m_cnt == m_cmp[i]);
    end
    frc = (wr_en && addr == 4'd1 && !hold_force) ? wdata[3:2] : 2'b00;
    old_flag = m_flag;
    for (int i = 0; i < 2; i++) begin
      if (mt[i]) m_flag[i] = 1;
      else if (lo_acc[i] && m_clr[i]) m_flag[i] = 0;
      if (rd_en && addr == 4'd2) m_clr[i] = old_flag[i];
      else if (lo_acc[i]) m_clr[i] = 0;
      if (frc[i]) m_pin[i] = wdata[i];
      else if (mt[i] && m_en[i]) m_pin[i] = m_lvl[i];
      if (hi_wr[i]) begin m_cmp[i][15:8] = wdata; m_arm[i] = 1; end
      if (lo_wr[i]) begin m_cmp[i][7:0] = wdata; m_arm[i] = 0; end
    end
    if (wr_en && addr == 4'd0) begin
      m_ps = wdata[1:0]; m_ie = wdata[2]; m_en = wdata[4:3];
    end
    if (wr_en && addr == 4'd1) m_lvl = wdata[1:0];
    m_div = m_div + 3'd1;
    m_pv = m_s1; m_s1 = m_s0; m_s0 = ext_clk;
    if (tk) m_cnt = m_cnt + 16'd1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 0; mreset();
    end else begin
      logic old;
      old = m_rs[1];
      m_rs = {m_rs[0], 1'b1};
      if (!old) mreset(); else mstep();
    end
  end

  function automatic logic [7:0] m_read(logic [3:0] a);
    case (a)
      4'd0:  return {3'b000, m_en, m_ie, m_ps};
      4'd1:  return {6'b0, m_lvl};
      4'd2:  return {6'b0, m_flag};
      4'd3:  return m_cmp[0][15:8];
      4'd4:  return m_cmp[0][7:0];
      4'd5:  return m_cmp[1][15:8];
      4'd6:  return m_cmp[1][7:0];
      4'd14: return m_cnt[15:8];
      4'd15: return m_cnt[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check("R6 pin_q", 16'(pin_q), 16'(m_pin));
    check("R7 pin_oe", 16'(pin_oe), 16'(m_en));
    check("R9 irq", 16'(irq), 16'(m_ie && (m_flag != 0)));
    if (rd_en) check({cur_tag, " rdata"}, 16'(rdata), 16'(m_read(addr)));
  endtask

  task automatic step();
    #5;
    check_all();
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1; step();
  endtask

  task automatic rd(logic [3:0] a, string tag);
    addr = a; rd_en = 1; cur_tag = tag; step(); cur_tag = "";
  endtask

  task automatic set_cmp(int ch, logic [15:0] v);
    wr(4'(3 + 2 * ch), v[15:8]);
    wr(4'(4 + 2 * ch), v[7:0]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; addr = 0; wr_en = 0; rd_en = 0; wdata = 0;
    ext_clk = 0; hold_force = 0;
    mreset(); m_rs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);
    // R1: reset values at the ports
    check("R1 pin_q", 16'(pin_q), 16'h0);
    check("R1 pin_oe", 16'(pin_oe), 16'h0);
    check("R1 irq", 16'(irq), 16'h0);
    rd(4'd2, "R1");
    rd(4'd0, "R1");
    rd(4'd15, "R2");
    // R3: divide-by-2, both channels enabled, interrupt on
    wr(4'd0, 8'h1C);
    wr(4'd1, 8'h01);
    set_cmp(0, m_cnt + 16'd20);
    set_cmp(1, m_cnt + 16'd40);
    idle(100);
    rd(4'd2, "R3");
    rd(4'd14, "R2");
    rd(4'd15, "R2");
    // R10: flag clear sequence
    rd(4'd4, "R10");
    rd(4'd2, "R10");
    rd(4'd4, "R10");
    rd(4'd2, "R10");
    rd(4'd6, "R10");
    rd(4'd2, "R10");
    // R6: level 0 on channel 0
    wr(4'd1, 8'h02);
    set_cmp(0, m_cnt + 16'd10);
    idle(30);
    // R6: channel 0 disabled, latch holds, flag still sets
    wr(4'd0, 8'h14);
    wr(4'd1, 8'h01);
    set_cmp(0, m_cnt + 16'd10);
    idle(30);
    rd(4'd2, "R6");
    // R5: upper-byte lockout
    rd(4'd2, "R5"); rd(4'd4, "R5"); rd(4'd6, "R5");
    wr(4'd0, 8'h1C);
    set_cmp(0, m_cnt + 16'd14);
    wr(4'd3, m_cmp[0][15:8]);
    idle(40);
    rd(4'd2, "R5");
    check("R5 flag0 locked", 16'(m_flag[0]), 16'h0);
    set_cmp(0, m_cnt + 16'd12);
    idle(40);
    rd(4'd2, "R5");
    // R8: force, then force blocked by hold_force
    rd(4'd2, "R8"); rd(4'd4, "R8"); rd(4'd6, "R8");
    wr(4'd1, 8'h0D);
    rd(4'd2, "R8");
    wr(4'd1, 8'h0E);
    rd(4'd2, "R8");
    hold_force = 1;
    wr(4'd1, 8'h0D);
    idle(2);
    hold_force = 0;
    // R11: readback masking
    rd(4'd1, "R11");
    rd(4'd2, "R11");
    rd(4'd0, "R11");
    rd(4'd7, "R11");
    // R4: divide-by-4 and divide-by-8
    wr(4'd0, 8'h1D);
    set_cmp(1, m_cnt + 16'd5);
    idle(60);
    rd(4'd2, "R4");
    rd(4'd15, "R2");
    wr(4'd0, 8'h1E);
    set_cmp(0, m_cnt + 16'd4);
    idle(80);
    rd(4'd2, "R4");
    // R2/R4: external clock
    wr(4'd0, 8'h1F);
    set_cmp(1, m_cnt + 16'd5);
    for (int k = 0; k < 40; k++) begin
      ext_clk = ~ext_clk;
      idle(3);
    end
    rd(4'd15, "R2");
    rd(4'd2, "R4");
    idle(4);
    finish_run();
  end
endmodule